// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Runtime Write Policy

This block is a direct-mapped data cache. It sits between a CPU load/store port and a backing memory that transfers one 32-bit word at a time. The cache holds 64 lines of four words (16 bytes each). Every line has a valid bit, a dirty bit and a tag. A read miss copies the whole line from memory and then returns the requested word.

A single input selects the write policy for each access. When it is low, the cache is write-through. Stores post their memory write into a four-entry queue, and a store that misses does not allocate a line. When it is high, the cache is write-back. Stores update only the cached line and mark it dirty, and a store that misses fetches the line first and then merges the stored word. A miss whose victim line is dirty writes that line back before the refill, whatever the current policy is.

The CPU holds its request until `cpu_done` is high. On a lookup hit, `cpu_done` goes high in the same cycle as the request, and the access completes at the next rising edge. Two counters report how many completed accesses hit and how many missed.

Top module: `dmc_cache`

## Requirements
- R1: Reset (synchronous, active low) clears every valid bit, every dirty bit and both counters, and leaves `mem_req` low. The first access after reset is therefore a miss.
- R2: The byte address is split into three fields: tag = bits 31..10, line index = bits 9..4, word within line = bits 3..2. Byte address 1200 maps to index 11, so it competes for the same line as byte address 0x8B0.
- R3: A lookup hits when the indexed line is valid and its tag matches. A read hit raises `cpu_done` with the word in the same cycle as the request.
- R4: A read miss reads four words from memory, starting at the line's base word address and going upward, and then returns the requested word.
- R5: Write-through mode (`policy_wb`=0), write hit: the cached word is updated and a memory write is posted to a 4-entry queue. The CPU stalls only while that queue is full.
- R6: Write-through mode, write miss: no line is fetched and none is allocated. The write goes only into the queue.
- R7: Write-back mode (`policy_wb`=1), write hit: only the cached word changes and the line becomes dirty. Memory is unchanged until the line is evicted.
- R8: Any miss whose victim line is valid and dirty first writes all four words of that line to memory, at the victim's address, and then refills. This happens in both modes.
- R9: Write-back mode, write miss: the line is fetched and the stored word is then merged into it, so the line ends dirty.
- R10: Exactly one of `hit_count` or `miss_count` increments per completed access. It is `hit_count` when the lookup hit at the start of the access. Neither counter changes otherwise.
- R11: The memory port holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack`. Each ack moves one word, and on a read `mem_rdata` is valid in the ack cycle.
- R12: A read miss waits until the write queue is empty before it fetches, so it never returns data older than a queued write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_wb | input | 1 | 1 = write-back/allocate, 0 = write-through/no-allocate |
| cpu_req | input | 1 | Access request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| cpu_done | output | 1 | Access completes at the next rising edge |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer of one word complete |
| hit_count | output | 16 | Completed accesses that hit |
| miss_count | output | 16 | Completed accesses that missed |

## Verification
The hardest case to reach is a read miss to a word whose write-around store is still waiting in the posted queue. It only arises when stores arrive faster than memory accepts them. The bench slows the memory acknowledge to several cycles, issues a burst of write-through stores to unallocated lines until one of them stalls, and then at once reads back the last store's address. A second hard case is a dirty line evicted while write-through mode is selected. It is reached by dirtying a line in write-back mode and then missing on the same index after the mode is switched.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache controller.
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_EVICT,
        ST_FILL,
        ST_FINISH
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
// Tag, valid and dirty arrays for a direct-mapped cache.
// Assumes one index per cycle; install and dirty_set share that index.
module dmc_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             install,
    input  logic [TAG_W-1:0] install_tag,
    input  logic             dirty_set,
    output logic             valid_o,
    output logic             dirty_o,
    output logic [TAG_W-1:0] tag_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid and dirty state: cleared on reset, set on install or store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_set) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    // Tag storage: written when a line is installed
    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= install_tag;
        end
    end

    // Asynchronous lookup of the indexed entry
    always_comb begin
        valid_o = valid_q[idx];
        dirty_o = dirty_q[idx];
        tag_o   = tag_q[idx];
    end
endmodule

// File: rtl/dmc_data_store.sv
// Line data storage, one word per entry, addressed by {index, word}.
// Assumes a single write port and one combinational read port.
module dmc_data_store #(
    parameter int IDX_W  = 6,
    parameter int BEAT_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [DATA_W-1:0] wr_word
);
    localparam int ENTRIES = 1 << (IDX_W + BEAT_W);

    logic [DATA_W-1:0] word_q [ENTRIES];

    // Word write from a refill beat or a CPU store
    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{idx, wr_beat}] <= wr_word;
        end
    end

    // Combinational word read
    always_comb begin
        rd_word = word_q[{idx, rd_beat}];
    end
endmodule

// File: rtl/dmc_wr_queue.sv
// Posted write queue: FIFO of {word address, data} pairs.
// Assumes the caller never pushes when full nor pops when empty.
module dmc_wr_queue #(
    parameter int DEPTH  = 4,
    parameter int AW     = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [AW-1:0]     head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]     addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    // Head and status outputs
    always_comb begin
        head_addr = addr_q[rd_ptr_q];
        head_data = data_q[rd_ptr_q];
        empty     = (count_q == '0);
        full      = (count_q == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped cache controller with runtime write-policy select.
// Assumes the CPU holds request fields stable until cpu_done, and the
// memory acknowledges each word with mem_ack (read data valid with ack).
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 6,
    parameter int OFF_W    = 4,
    parameter int WQ_DEPTH = 4,
    parameter int CNT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       policy_wb,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       cpu_done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_ack,
    output logic [CNT_W-1:0]           hit_count,
    output logic [CNT_W-1:0]           miss_count
);
    localparam int WORD_OFF = $clog2(DATA_W / 8);
    localparam int BEAT_W   = OFF_W - WORD_OFF;
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int MADDR_W  = ADDR_W - WORD_OFF;

    // Address fields
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [BEAT_W-1:0] req_beat;
    logic [WORD_OFF-1:0] unused_byte_sel;

    assign req_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx         = cpu_addr[OFF_W +: IDX_W];
    assign req_beat        = cpu_addr[WORD_OFF +: BEAT_W];
    assign unused_byte_sel = cpu_addr[WORD_OFF-1:0];

    dmc_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              beat_inc;
    logic              last_beat;

    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              lookup_hit;
    logic              in_idle;
    logic              install, dirty_set;
    logic              cpu_wr, fill_wr;
    logic              fsm_owns, fsm_we;
    logic [DATA_W-1:0] line_word;
    logic [BEAT_W-1:0] rd_beat;

    logic              wq_push, wq_pop, wq_empty, wq_full;
    logic [MADDR_W-1:0] wq_head_addr;
    logic [DATA_W-1:0]  wq_head_data;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .install    (install),
        .install_tag(req_tag),
        .dirty_set  (dirty_set),
        .valid_o    (line_valid),
        .dirty_o    (line_dirty),
        .tag_o      (line_tag)
    );

    dmc_data_store #(.IDX_W(IDX_W), .BEAT_W(BEAT_W), .DATA_W(DATA_W)) data_i (
        .clk    (clk),
        .idx    (req_idx),
        .rd_beat(rd_beat),
        .rd_word(line_word),
        .wr_en  (cpu_wr | fill_wr),
        .wr_beat(fill_wr ? beat_q : req_beat),
        .wr_word(fill_wr ? mem_rdata : cpu_wdata)
    );

    dmc_wr_queue #(.DEPTH(WQ_DEPTH), .AW(MADDR_W), .DATA_W(DATA_W)) wq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wq_push),
        .push_addr(cpu_addr[ADDR_W-1:WORD_OFF]),
        .push_data(cpu_wdata),
        .pop      (wq_pop),
        .head_addr(wq_head_addr),
        .head_data(wq_head_data),
        .empty    (wq_empty),
        .full     (wq_full)
    );

    // Lookup result and shared decode
    always_comb begin
        lookup_hit = line_valid && (line_tag == req_tag);
        in_idle    = (state_q == ST_IDLE);
        last_beat  = (beat_q == BEAT_W'((1 << BEAT_W) - 1));
        fsm_owns   = (state_q == ST_EVICT) || (state_q == ST_FILL);
        rd_beat    = (state_q == ST_EVICT) ? beat_q : req_beat;
        cpu_rdata  = line_word;
    end

    // Access sequencing: hit handling, drain, eviction, refill, completion
    always_comb begin
        state_d   = state_q;
        cpu_done  = 1'b0;
        wq_push   = 1'b0;
        dirty_set = 1'b0;
        install   = 1'b0;
        cpu_wr    = 1'b0;
        fill_wr   = 1'b0;
        beat_inc  = 1'b0;
        fsm_we    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        if (!cpu_we) begin
                            cpu_done = 1'b1;
                        end else if (policy_wb) begin
                            cpu_done  = 1'b1;
                            cpu_wr    = 1'b1;
                            dirty_set = 1'b1;
                        end else if (!wq_full) begin
                            cpu_done = 1'b1;
                            cpu_wr   = 1'b1;
                            wq_push  = 1'b1;
                        end
                    end else if (cpu_we && !policy_wb) begin
                        if (!wq_full) begin
                            cpu_done = 1'b1;
                            wq_push  = 1'b1;
                        end
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (wq_empty) begin
                    state_d = (line_valid && line_dirty) ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                fsm_we = 1'b1;
                if (mem_ack) begin
                    beat_inc = 1'b1;
                    if (last_beat) state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    beat_inc = 1'b1;
                    fill_wr  = 1'b1;
                    if (last_beat) begin
                        install = 1'b1;
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                cpu_done = 1'b1;
                if (cpu_we) begin
                    cpu_wr    = 1'b1;
                    dirty_set = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory port: refill/eviction owns it, otherwise the queue drains
    always_comb begin
        if (fsm_owns) begin
            mem_req   = 1'b1;
            mem_we    = fsm_we;
            mem_addr  = {(fsm_we ? line_tag : req_tag), req_idx, beat_q};
            mem_wdata = line_word;
            wq_pop    = 1'b0;
        end else begin
            mem_req   = !wq_empty;
            mem_we    = 1'b1;
            mem_addr  = wq_head_addr;
            mem_wdata = wq_head_data;
            wq_pop    = !wq_empty && mem_ack;
        end
    end

    // State and beat counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (beat_inc) beat_q <= beat_q + 1'b1;
        end
    end

    // Hit and miss counters, one step per completed access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (cpu_done) begin
            if (in_idle && lookup_hit) hit_count <= hit_count + 1'b1;
            else                       miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/dmc_cache_chk.sv
// Property checker for dmc_cache, attached by bind.
module dmc_cache_chk #(
    parameter int MADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_done,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [MADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count,
    input logic               state_idle,
    input logic               lookup_hit,
    input logic               wq_full
);
    logic [CNT_W:0] total;
    assign total = {1'b0, hit_count} + {1'b0, miss_count};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hit_count == '0 && miss_count == '0 && !mem_req));

    assert_stall_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_idle && cpu_req && lookup_hit && !cpu_done) |-> wq_full);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (total == $past(total) + 1'b1));

    assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_done |=> ($stable(hit_count) && $stable(miss_count)));

    assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
endmodule

bind dmc_cache dmc_cache_chk #(
    .MADDR_W(MADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_done  (cpu_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .hit_count (hit_count),
    .miss_count(miss_count),
    .state_idle(in_idle),
    .lookup_hit(lookup_hit),
    .wq_full   (wq_full)
);

// File: tb/dmc_cache_tb_top.sv
// Self-checking bench for dmc_cache: vector table, then directed tests.
module dmc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        policy_wb = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wait_cnt = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    logic [29:0] last_rd = '0;
    bit mem_ready = 0;
    logic [31:0] bmem [4096];
    logic [31:0] refm [4096];

    always #10 clk = ~clk;

    dmc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .policy_wb(policy_wb),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] finit(input int i);
        return {16'(i) ^ 16'hA5A5, 16'(i)};
    endfunction

    // Backing memory: one word per ack after lat wait cycles
    always @(posedge clk) begin
        if (!mem_ready) begin
            for (int i = 0; i < 4096; i++) bmem[i] <= finit(i);
            mem_ready <= 1'b1;
        end
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                if (mem_we) begin
                    bmem[mem_addr[11:0]] <= mem_wdata;
                    wr_beats <= wr_beats + 1;
                end else begin
                    mem_rdata <= bmem[mem_addr[11:0]];
                    last_rd   <= mem_addr;
                    rd_beats  <= rd_beats + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic access(input logic wb, input logic we, input logic [31:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output int cyc);
        bit got;
        got = 0;
        cyc = 0;
        rd  = '0;
        @(negedge clk);
        policy_wb = wb; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
        while (!got && cyc < 2000) begin
            #2;
            cyc++;
            if (cpu_done) begin
                got = 1;
                rd  = cpu_rdata;
            end
            @(negedge clk);
        end
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        if (!got) chk(0, "R3", "access never completed", 0, 1);
        if (we) refm[a[13:2]] = d;
    endtask

    // Vector: {policy_wb, we, addr, wdata, expect_hit}
    localparam int NV = 13;
    localparam logic [66:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0000_04B0, 32'h0, 1'b0},
        {1'b0, 1'b0, 32'h0000_04B4, 32'h0, 1'b1},
        {1'b0, 1'b1, 32'h0000_04B8, 32'h1111_1111, 1'b1},
        {1'b0, 1'b0, 32'h0000_04B8, 32'h0, 1'b1},
        {1'b0, 1'b1, 32'h0000_08B0, 32'h2222_2222, 1'b0},
        {1'b0, 1'b0, 32'h0000_04B0, 32'h0, 1'b1},
        {1'b0, 1'b0, 32'h0000_08B0, 32'h0, 1'b0},
        {1'b1, 1'b1, 32'h0000_08BC, 32'h3333_3333, 1'b1},
        {1'b0, 1'b0, 32'h0000_04B0, 32'h0, 1'b0},
        {1'b0, 1'b0, 32'h0000_08BC, 32'h0, 1'b0},
        {1'b1, 1'b1, 32'h0000_0C40, 32'h4444_4444, 1'b0},
        {1'b0, 1'b0, 32'h0000_0C40, 32'h0, 1'b1},
        {1'b0, 1'b0, 32'h0000_0C44, 32'h0, 1'b1}
    };

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc, h0, m0, rb0, wb0, maxcyc, firstcyc;
        for (int i = 0; i < 4096; i++) refm[i] = finit(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset", {hit_count, miss_count}, 0);
        chk(!mem_req && !cpu_done, "R1", "idle memory port after reset", {30'd0, mem_req, cpu_done}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] exp_rd;
            h0 = hit_count; m0 = miss_count; rb0 = rd_beats; wb0 = wr_beats;
            exp_rd = refm[VEC[i][46:35]];
            access(VEC[i][66], VEC[i][65], VEC[i][64:33], VEC[i][32:1], rd, cyc);
            if (VEC[i][0])
                chk(hit_count == h0 + 1 && miss_count == m0, "R10", $sformatf("vec %0d hit count", i), hit_count, 16'(h0 + 1));
            else
                chk(miss_count == m0 + 1 && hit_count == h0, "R10", $sformatf("vec %0d miss count", i), miss_count, 16'(m0 + 1));
            if (!VEC[i][65])
                chk(rd == exp_rd, "R3", $sformatf("vec %0d read data", i), rd, exp_rd);
            if (i == 0) begin
                // R2/R4: 1200 is index 11; line base word 0x12C, four beats up to 0x12F
                chk(rd_beats - rb0 == 4, "R4", "refill beat count", rd_beats - rb0, 4);
                chk(last_rd == 30'h12F, "R2", "refill last word address", {2'b0, last_rd}, 32'h12F);
            end
            if (i == 1) chk(cyc == 1, "R3", "read hit latency", cyc, 1);
            if (i == 4) chk(rd_beats == rb0, "R6", "write-around fetched nothing", rd_beats - rb0, 0);
            if (i == 6) chk(rd == 32'h2222_2222, "R12", "read miss sees queued write", rd, 32'h2222_2222);
            if (i == 8) chk(wr_beats - wb0 == 4, "R8", "dirty victim write-back beats", wr_beats - wb0, 4);
            if (i == 10) chk(rd_beats - rb0 == 4, "R9", "write-allocate fetched line", rd_beats - rb0, 4);
        end
        chk(hit_count == 7 && miss_count == 6, "R10", "table totals", {hit_count, miss_count}, {16'd7, 16'd6});
        chk(bmem[12'h12E] == 32'h1111_1111, "R5", "write-through hit reached memory", bmem[12'h12E], 32'h1111_1111);
        chk(bmem[12'h22F] == 32'h3333_3333, "R8", "evicted dirty word in memory", bmem[12'h22F], 32'h3333_3333);

        // R7: write-back hit leaves memory alone
        wb0 = wr_beats; h0 = hit_count;
        access(1'b1, 1'b1, 32'h0000_0C48, 32'h5555_5555, rd, cyc);
        chk(hit_count == h0 + 1, "R7", "write-back store hit", hit_count, 16'(h0 + 1));
        repeat (20) @(negedge clk);
        chk(wr_beats == wb0, "R7", "no memory write on write-back hit", wr_beats - wb0, 0);
        chk(bmem[12'h312] == finit(12'h312), "R7", "memory word unchanged", bmem[12'h312], finit(12'h312));
        // R8: dirty line evicted while write-through is selected
        access(1'b0, 1'b0, 32'h0000_0048, 32'h0, rd, cyc);
        chk(rd == refm[12'h012], "R8", "conflict read data", rd, refm[12'h012]);
        chk(wr_beats - wb0 == 4, "R8", "eviction beats in write-through mode", wr_beats - wb0, 4);
        chk(bmem[12'h312] == 32'h5555_5555, "R8", "merged word written back", bmem[12'h312], 32'h5555_5555);
        chk(bmem[12'h310] == 32'h4444_4444, "R9", "allocated store written back", bmem[12'h310], 32'h4444_4444);

        // R5/R12: slow memory, burst of write-around stores, then read back
        lat = 3;
        maxcyc = 0; firstcyc = 0;
        for (int k = 0; k < 8; k++) begin
            access(1'b0, 1'b1, 32'h0000_2000 + 32'(k * 16), 32'hA000_0000 + 32'(k), rd, cyc);
            if (k == 0) firstcyc = cyc;
            if (cyc > maxcyc) maxcyc = cyc;
        end
        chk(firstcyc == 1, "R5", "store into empty queue does not stall", firstcyc, 1);
        chk(maxcyc > 1, "R5", "store stalls on full queue", maxcyc, 2);
        access(1'b0, 1'b0, 32'h0000_2070, 32'h0, rd, cyc);
        chk(rd == 32'hA000_0007, "R12", "read miss after queued store", rd, 32'hA000_0007);
        repeat (60) @(negedge clk);
        for (int k = 0; k < 8; k++)
            chk(bmem[12'h800 + 12'(k * 4)] == 32'hA000_0000 + 32'(k), "R6",
                $sformatf("queued store %0d in memory", k), bmem[12'h800 + 12'(k * 4)], 32'hA000_0000 + 32'(k));
        lat = 0;

        // R1: reset mid-run clears valid bits and counters
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(hit_count == 0 && miss_count == 0, "R1", "counters after second reset", {hit_count, miss_count}, 0);
        access(1'b0, 1'b0, 32'h0000_04B0, 32'h0, rd, cyc);
        chk(miss_count == 1 && hit_count == 0, "R1", "first read after reset misses", miss_count, 1);
        chk(rd == refm[12'h12C], "R4", "refetched word after reset", rd, refm[12'h12C]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule